// File: doc/BRIEF.md
# Two-stage watchdog timer

The block watches for a periodic kick from software or hardware. A single down-counter runs in two stages in a row. The first stage times the normal kick interval. When it runs out, the block sets a sticky status flag and, if enabled, raises an interrupt. The counter then reloads from a second preload and runs a grace stage. If that stage also expires without a kick, a one-cycle timeout pulse is issued and the counter holds at zero. A kick at any time returns the timer to the start of stage one.

Each preload register holds only the upper bits of the counter. A load places the preload in the top `PRE_W` bits of the `CNT_W`-bit counter and fills the low `CNT_W-PRE_W` bits with ones. This gives a fixed prescale of 2^(CNT_W-PRE_W). The zero count is part of each stage, so software programs the wanted number of prescale units minus one.

The preload registers are protected by a two-key write unlock. In free-running mode the first stage simply repeats, without flagging and without ever entering stage two. All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake is used. A register write is accepted in every cycle in which `wr_en` is high.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, the first-stage preload (address 0) and the second-stage preload (address 1) read 2^PRE_W-1. The configuration (address 2) and status (address 3) registers read 0, and `irq` and `timeout` are low.
- R2: With a first-stage preload P1, status bit 0 becomes set (P1+1)·2^(CNT_W-PRE_W) clock edges after the edge that samples a kick.
- R3: With a second-stage preload P2, `timeout` pulses (P2+1)·2^(CNT_W-PRE_W) edges after the edge that set the status flag. The pulse is exactly one cycle wide.
- R4: After a timeout, the counter holds at zero and no further pulse appears until a kick. A kick then restarts stage one with the full timing of R2 and R3.
- R5: Status bit 0 is sticky. A write to address 3 with data bit 0 = 1 clears it, a write with bit 0 = 0 leaves it set, and status bits above bit 0 read zero.
- R6: `irq` follows status bit 0 while configuration bit 0 (interrupt enable) is 1. It stays low while that bit is 0, even with the flag set.
- R7: With configuration bit 1 (free-run) set, first-stage expiry reloads stage one. The status flag is never set and `timeout` never pulses.
- R8: A kick during stage two cancels the pending timeout, and new stage timing is measured from that kick.
- R9: A write to address 0 or 1 changes the preload only when the two writes before it went to address 4, first with data KEY_A (0x5A) and then with data KEY_B (0xC3). Exactly one write consumes the unlock, whatever its address.
- R10: Any other write between the KEY_A and KEY_B writes cancels the unlock, and a following preload write is ignored.
- R11: Address 4 and the unused addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| kick | input | 1 | Reload request, returns the timer to stage one |
| irq | output | 1 | Interrupt: first-stage flag gated by the interrupt enable |
| timeout | output | 1 | One-cycle pulse on second-stage expiry |

## Verification
The hardest condition to reach from the ports is a kick that lands inside stage two, before the pending timeout. The bench sets the grace stage well longer than stage one. It waits a fixed number of cycles past the flag, clears the flag and kicks again. A timeout that still fired would show up as an early pulse in the measurement that follows. The exact-edge checks for stage length rely on the configuration write and the kick landing on the same edge, so the counter state at the kick is known. Preloads are programmed while free-run is active, so no flag can appear before the measured run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PRE1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRE2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd4;

  typedef enum logic [1:0] {
    STG_ONE  = 2'd0,
    STG_TWO  = 2'd1,
    STG_HOLD = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_ARMED = 2'd1,
    LK_OPEN  = 2'd2
  } lock_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 20,
  parameter int KEY_A  = 'h5A,
  parameter int KEY_B  = 'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              exp1_set,
  output logic [PRE_W-1:0]  pre1,
  output logic [PRE_W-1:0]  pre2,
  output logic              irq_en,
  output logic              free_run,
  output logic              sts_flag,
  output logic              unlocked,
  output logic [DATA_W-1:0] rdata
);
  lock_e lk_q;

  logic key_a_hit, key_b_hit;
  assign key_a_hit = (addr == A_KEY) && (wdata == DATA_W'(KEY_A));
  assign key_b_hit = (addr == A_KEY) && (wdata == DATA_W'(KEY_B));
  assign unlocked  = (lk_q == LK_OPEN);

  // unlock sequencer: every write advances or resets it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q <= LK_IDLE;
    end else if (wr_en) begin
      case (lk_q)
        LK_IDLE:  lk_q <= key_a_hit ? LK_ARMED : LK_IDLE;
        LK_ARMED: lk_q <= key_b_hit ? LK_OPEN  : LK_IDLE;
        default:  lk_q <= LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1     <= '1;
      pre2     <= '1;
      irq_en   <= 1'b0;
      free_run <= 1'b0;
    end else if (wr_en) begin
      if (unlocked && addr == A_PRE1) pre1 <= wdata[PRE_W-1:0];
      if (unlocked && addr == A_PRE2) pre2 <= wdata[PRE_W-1:0];
      if (addr == A_CFG) begin
        irq_en   <= wdata[0];
        free_run <= wdata[1];
      end
    end
  end

  // sticky first-stage flag, set has priority over write-one-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_flag <= 1'b0;
    end else if (exp1_set) begin
      sts_flag <= 1'b1;
    end else if (wr_en && addr == A_STAT && wdata[0]) begin
      sts_flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PRE1: rdata = DATA_W'(pre1);
      A_PRE2: rdata = DATA_W'(pre2);
      A_CFG:  rdata = DATA_W'({free_run, irq_en});
      A_STAT: rdata = DATA_W'(sts_flag);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W = 35,
  parameter int PRE_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  input  logic             free_run,
  output logic             exp1_set,
  output logic             tmo,
  output stage_e           stage,
  output logic [CNT_W-1:0] cnt
);
  localparam int LOW_W = CNT_W - PRE_W;

  function automatic logic [CNT_W-1:0] load_val(input logic [PRE_W-1:0] p);
    return {p, {LOW_W{1'b1}}};
  endfunction

  logic at_zero;
  assign at_zero  = (cnt == '0);
  assign exp1_set = (stage == STG_ONE) && at_zero && !free_run && !kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '1;
      stage <= STG_ONE;
      tmo   <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (kick) begin
        cnt   <= load_val(pre1);
        stage <= STG_ONE;
      end else begin
        case (stage)
          STG_ONE: begin
            if (!at_zero) begin
              cnt <= cnt - 1'b1;
            end else if (free_run) begin
              cnt <= load_val(pre1);
            end else begin
              cnt   <= load_val(pre2);
              stage <= STG_TWO;
            end
          end
          STG_TWO: begin
            if (!at_zero) begin
              cnt <= cnt - 1'b1;
            end else begin
              tmo   <= 1'b1;
              stage <= STG_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 35,
  parameter int PRE_W  = 20,
  parameter int DATA_W = 32,
  parameter int KEY_A  = 'h5A,
  parameter int KEY_B  = 'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              kick,
  output logic              irq,
  output logic              timeout
);
  logic [PRE_W-1:0] pre1, pre2;
  logic             irq_en, free_run, sts_flag, unlocked, exp1_set;
  stage_e           stage;
  logic [CNT_W-1:0] cnt;

  wdt_regs #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .exp1_set(exp1_set), .pre1(pre1), .pre2(pre2), .irq_en(irq_en),
    .free_run(free_run), .sts_flag(sts_flag), .unlocked(unlocked),
    .rdata(rdata)
  );

  wdt_core #(
    .CNT_W(CNT_W), .PRE_W(PRE_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .kick(kick), .pre1(pre1), .pre2(pre2),
    .free_run(free_run), .exp1_set(exp1_set), .tmo(timeout),
    .stage(stage), .cnt(cnt)
  );

  assign irq = sts_flag & irq_en;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 35,
  parameter int PRE_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              clr_bit,
  input logic              kick,
  input logic              tmo,
  input logic              irq,
  input logic              sts_flag,
  input logic              free_run,
  input logic [1:0]        stage,
  input logic [CNT_W-1:0]  cnt,
  input logic              unlocked,
  input logic [PRE_W-1:0]  pre1,
  input logic [PRE_W-1:0]  pre2
);
  // R3
  tmo_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo);

  // R4
  tmo_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> (cnt == '0));

  // R5
  flag_only_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_flag) |-> $past(wr_en && addr == A_STAT && clr_bit));

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts_flag);

  // R7
  free_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_flag) |-> !$past(free_run));

  // R8
  kick_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (stage == 2'(STG_ONE)));

  // R9
  pre_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pre1) || !$stable(pre2)) |-> $past(unlocked));
endmodule

bind twostage_wdt wdt_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .clr_bit(wdata[0]),
  .kick(kick), .tmo(timeout), .irq(irq), .sts_flag(sts_flag),
  .free_run(free_run), .stage(stage), .cnt(cnt), .unlocked(unlocked),
  .pre1(pre1), .pre2(pre2)
);

// File: tb/twostage_wdt_tb.sv
`timescale 1ns/1ps
module twostage_wdt_tb;
  localparam int CNT_W = 8;
  localparam int PRE_W = 4;
  localparam int DATA_W = 32;
  localparam int PRESC = 1 << (CNT_W - PRE_W);
  localparam int KA = 'h5A;
  localparam int KB = 'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic kick = 1'b0;
  logic irq, timeout;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  twostage_wdt #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .kick(kick), .irq(irq), .timeout(timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] a, input int d, input logic k);
    @(negedge clk);
    wr_en = w; addr = a; wdata = DATA_W'(d); kick = k;
    @(negedge clk);
    wr_en = 1'b0; kick = 1'b0; addr = 3'd3;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic unlock_write(input logic [2:0] a, input int d);
    step(1'b1, 3'd4, KA, 1'b0);
    step(1'b1, 3'd4, KB, 1'b0);
    step(1'b1, a, d, 1'b0);
  endtask

  // program preloads quietly in free-run, clear flag, then cfg + kick on one edge
  task automatic prog(input int p1, input int p2, input int cfg);
    step(1'b1, 3'd2, 2, 1'b0);
    unlock_write(3'd0, p1);
    unlock_write(3'd1, p2);
    step(1'b1, 3'd3, 1, 1'b0);
    step(1'b1, 3'd2, cfg, 1'b1);
  endtask

  // counts negedges after the kick edge; addr is already at status
  task automatic measure(output int t1, output int tt, output int wide);
    t1 = -1; tt = -1; wide = 0;
    for (int n = 1; n <= 3000; n++) begin
      @(negedge clk);
      if (rdata[0] && t1 < 0) t1 = n;
      if (timeout) begin
        tt = n;
        @(negedge clk);
        wide = int'(timeout);
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, t1, tt, wide, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(3'd0, v); chk("R1 pre1 reset", v, (1 << PRE_W) - 1);
    rd(3'd1, v); chk("R1 pre2 reset", v, (1 << PRE_W) - 1);
    rd(3'd2, v); chk("R1 cfg reset", v, 0);
    rd(3'd3, v); chk("R1 stat reset", v, 0);
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 timeout reset", int'(timeout), 0);
    // R11 key and unused addresses
    for (int a = 4; a < 8; a++) begin
      rd(3'(a), v); chk("R11 unused addr reads zero", v, 0);
    end

    // R9 locked write ignored
    step(1'b1, 3'd0, 3, 1'b0);
    rd(3'd0, v); chk("R9 locked write ignored", v, 15);
    // R10 intervening write cancels
    step(1'b1, 3'd4, KA, 1'b0);
    step(1'b1, 3'd2, 0, 1'b0);
    step(1'b1, 3'd4, KB, 1'b0);
    step(1'b1, 3'd0, 3, 1'b0);
    rd(3'd0, v); chk("R10 broken key sequence", v, 15);
    // R9 proper unlock then one-shot
    unlock_write(3'd0, 3);
    rd(3'd0, v); chk("R9 unlocked write taken", v, 3);
    step(1'b1, 3'd0, 5, 1'b0);
    rd(3'd0, v); chk("R9 unlock consumed", v, 3);
    unlock_write(3'd1, 9);
    rd(3'd1, v); chk("R9 pre2 unlocked write", v, 9);

    // R2 R3 R4: sweep both preloads, each run restarted by kick from hold
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 2; q++) begin
        int p2 = (q == 0) ? 15 - p : p;
        prog(p, p2, 1);
        measure(t1, tt, wide);
        chk("R2 stage one length", t1, (p + 1) * PRESC);
        chk("R3 timeout instant", tt, (p + 1) * PRESC + (p2 + 1) * PRESC);
        chk("R3 pulse one cycle", wide, 0);
      end
    end

    // R4 hold after timeout
    seen = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (timeout) seen++;
    end
    chk("R4 no pulse while holding", seen, 0);

    // R5 sticky flag
    rd(3'd3, v); chk("R5 flag set, upper bits zero", v, 1);
    step(1'b1, 3'd3, 0, 1'b0);
    rd(3'd3, v); chk("R5 write 0 no effect", v, 1);
    step(1'b1, 3'd3, 'hFE, 1'b0);
    rd(3'd3, v); chk("R5 write bit0=0 no effect", v, 1);
    chk("R6 irq with enable", int'(irq), 1);
    step(1'b1, 3'd3, 1, 1'b0);
    rd(3'd3, v); chk("R5 write 1 clears", v, 0);
    chk("R6 irq drops with flag", int'(irq), 0);

    // R6 interrupt disabled
    prog(0, 0, 0);
    measure(t1, tt, wide);
    chk("R6 flag sets with irq off", t1, PRESC);
    chk("R6 irq stays low", int'(irq), 0);
    step(1'b1, 3'd2, 1, 1'b0);
    chk("R6 irq after enabling", int'(irq), 1);

    // R7 free-running
    prog(1, 0, 3);
    seen = 0;
    for (int n = 0; n < 10 * PRESC; n++) begin
      @(negedge clk);
      if (rdata[0] || timeout || irq) seen++;
    end
    chk("R7 no flag or timeout in free-run", seen, 0);

    // R8 kick during stage two
    prog(0, 3, 1);
    repeat (PRESC + 10) @(negedge clk);
    rd(3'd3, v); chk("R8 in stage two flag set", v, 1);
    step(1'b1, 3'd3, 1, 1'b0);
    step(1'b0, 3'd3, 0, 1'b1);
    measure(t1, tt, wide);
    chk("R8 flag timing from new kick", t1, PRESC);
    chk("R8 timeout timing from new kick", tt, PRESC + 4 * PRESC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule